// File: doc/BRIEF.md
# Byte-Region Checksum Engine

This block computes a 16-bit checksum over a run of bytes in a byte-wide memory and can store the result in that same memory. A request gives a start address, a byte count and an optional store address. The engine reads each byte of the region once, in ascending order, through a synchronous read port. It pairs neighbouring bytes into big-endian 16-bit words that overlap by one byte. Each word passes through a nibble-folding update, starting from an all-ones accumulator.

If the count is odd, the last byte is folded once more as the high half of a word whose low half is zero. When write-back is requested, the checksum goes out as two byte writes, high byte first, before completion is signalled. A typical use is to seal a configuration header: the region starts at offset 0, the count is 0xF8, and the checksum is stored as a big-endian word at offset 0xFC.

Top module: `nvram_cksum_engine`

## Requirements
- R1: `start` is taken only while `busy` is low. `busy` rises in the cycle after acceptance and stays high through the cycle in which `done` is high. A `start` seen while `busy` is high has no effect on the job in progress.
- R2: A byte count of zero raises `done` in the cycle after acceptance with `result` = 0xFFFF, and issues no memory read.
- R3: Each update takes the accumulator c and a word w. With p = c XOR w, a = p[3:0] and b = p[7:4] XOR a, the new value is (c >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12), kept to 16 bits. For example, c = 0xFFFF and w = 0x0000 give 0x0F87.
- R4: For an even count C > 0, exactly C words are folded, starting from 0xFFFF. Word i (0 ≤ i < C) carries byte[s+i] in bits 15:8 and byte[s+i+1] in bits 7:0. Three bytes of 0xFF at s with C = 2 give 0x0000.
- R5: For an odd count C, the first C-1 overlapping words are folded, then the word {byte[s+C-1], 0x00}. A count of 1 over a byte 0x00 gives 0x0F87.
- R6: Read data is used one cycle after its request. Each byte address is requested once, ascending by one from s in consecutive requests. An even count C > 0 makes C+1 requests and an odd count makes C.
- R7: With `wb_en` set at acceptance, the high byte of the checksum is written at `wb_addr` and the low byte at `wb_addr`+1, in two consecutive cycles. Both writes come before `done`, and never in a cycle that also reads.
- R8: `done` is high for exactly one cycle. `result` then holds its value until the next accepted `start`.
- R9: With `wb_en` clear at acceptance, the job makes no memory write.
- R10: A header sealed with count 0xF8 from offset 0 and write-back to 0xFC holds the result at 0xFC/0xFD. Recomputing over the same region afterwards gives the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a job; sampled only while idle |
| base_addr | input | AW | First byte address of the region |
| byte_cnt | input | CW | Number of bytes in the region |
| wb_en | input | 1 | Store the checksum at the end of the job |
| wb_addr | input | AW | Address of the stored high byte |
| busy | output | 1 | Job in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Checksum, valid from `done` until the next accepted start |
| mem_rd_en | output | 1 | Byte read request |
| mem_wr_en | output | 1 | Byte write request |
| mem_addr | output | AW | Address for the read or write |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the request |

## Verification
Two events can land in the same cycle: a new `start` arriving in the very cycle that `done` is high, and a new `start` while the fetch and fold pipeline is mid-stream. The bench raises `start` with different parameters in the done cycle and again in the middle of a long job. It then judges the outcome only at the ports. `busy` and `done` must both be low on the following cycle. The running job's result and read trace must match an independent model. `result` must stay unchanged after the refused request.

// File: rtl/nvck_pkg.sv
package nvck_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRIME,
        ST_FOLD,
        ST_PAD,
        ST_WB_HI,
        ST_WB_LO,
        ST_DONE
    } nvck_state_e;

    localparam logic [15:0] NVCK_SEED = 16'hFFFF;

endpackage

// File: rtl/nvck_fold.sv
module nvck_fold (
    input  logic [15:0] crc_in,
    input  logic [15:0] word_in,
    output logic [15:0] crc_out
);
    logic [15:0] mix;
    logic [3:0]  nib_a;
    logic [3:0]  nib_b;

    always_comb begin
        mix     = crc_in ^ word_in;
        nib_a   = mix[3:0];
        nib_b   = mix[7:4] ^ nib_a;
        crc_out = {8'h00, crc_in[15:8]}
                ^ {9'b0, nib_a, 3'b0}
                ^ {4'b0, nib_a, 8'b0}
                ^ {12'b0, nib_b}
                ^ {5'b0, nib_b, 7'b0}
                ^ {nib_b, 12'b0};
    end

    // equal operands cancel: only the shifted accumulator remains
    always_comb begin
        if (crc_in == word_in) begin
            AST_FOLD_SELF_CANCEL: assert (crc_out == {8'h00, crc_in[15:8]}); // R3
        end
    end

endmodule

// File: rtl/nvck_fetch.sv
module nvck_fetch #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] cnt_even,
    input  logic          cnt_zero,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [CW-1:0] left;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (load) begin
            f_d.en   = !cnt_zero;
            f_d.addr = base;
            f_d.left = cnt_zero ? '0 : cnt_even;
        end else if (f_q.en && (f_q.left != '0)) begin
            f_d.en   = 1'b1;
            f_d.addr = f_q.addr + AW'(1);
            f_d.left = f_q.left - CW'(1);
        end else begin
            f_d.en   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rd_en   = f_q.en;
    assign rd_addr = f_q.addr;

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + AW'(1))); // R6

endmodule

// File: rtl/nvck_ctrl.sv
module nvck_ctrl
    import nvck_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [CW-1:0] cnt_even,
    input  logic          cnt_odd,
    input  logic          cnt_zero,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [7:0]    rdata,
    input  logic [15:0]   fold_out,
    output logic [15:0]   fold_crc,
    output logic [15:0]   fold_word,
    output logic          busy,
    output logic          done,
    output logic [15:0]   crc,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    typedef struct packed {
        nvck_state_e   st;
        logic [15:0]   crc;
        logic [7:0]    prev;
        logic [CW-1:0] widx;
        logic [CW-1:0] nwords;
        logic          odd;
        logic          wb;
        logic [AW-1:0] wba;
        logic          wr_en;
        logic [AW-1:0] wr_addr;
        logic [7:0]    wr_data;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  finish;
    logic [15:0] crc_fin;

    assign fold_crc  = c_q.crc;
    assign fold_word = (c_q.st == ST_PAD) ? {c_q.prev, 8'h00} : {c_q.prev, rdata};

    always_comb begin
        c_d        = c_q;
        c_d.wr_en  = 1'b0;
        finish     = 1'b0;
        crc_fin    = c_q.crc;
        unique case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    c_d.crc    = NVCK_SEED;
                    c_d.nwords = cnt_even;
                    c_d.odd    = cnt_odd;
                    c_d.wb     = wb_en;
                    c_d.wba    = wb_addr;
                    c_d.widx   = '0;
                    crc_fin    = NVCK_SEED;
                    if (cnt_zero) finish = 1'b1;
                    else          c_d.st = ST_WAIT;
                end
            end
            ST_WAIT: c_d.st = ST_PRIME;
            ST_PRIME: begin
                c_d.prev = rdata;
                c_d.st   = (c_q.nwords == '0) ? ST_PAD : ST_FOLD;
            end
            ST_FOLD: begin
                c_d.crc  = fold_out;
                c_d.prev = rdata;
                crc_fin  = fold_out;
                if (c_q.widx == c_q.nwords - CW'(1)) begin
                    if (c_q.odd) c_d.st = ST_PAD;
                    else         finish = 1'b1;
                end else begin
                    c_d.widx = c_q.widx + CW'(1);
                end
            end
            ST_PAD: begin
                c_d.crc = fold_out;
                crc_fin = fold_out;
                finish  = 1'b1;
            end
            ST_WB_HI: begin
                c_d.wr_en   = 1'b1;
                c_d.wr_addr = c_q.wr_addr + AW'(1);
                c_d.wr_data = c_q.crc[7:0];
                c_d.st      = ST_WB_LO;
            end
            ST_WB_LO: c_d.st = ST_DONE;
            ST_DONE:  c_d.st = ST_IDLE;
            default:  c_d.st = ST_IDLE;
        endcase

        if (finish) begin
            if (c_d.wb) begin
                c_d.wr_en   = 1'b1;
                c_d.wr_addr = c_d.wba;
                c_d.wr_data = crc_fin[15:8];
                c_d.st      = ST_WB_HI;
            end else begin
                c_d.st      = ST_DONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.st  <= ST_IDLE;
            c_q.crc <= NVCK_SEED;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy    = (c_q.st != ST_IDLE);
    assign done    = (c_q.st == ST_DONE);
    assign crc     = c_q.crc;
    assign wr_en   = c_q.wr_en;
    assign wr_addr = c_q.wr_addr;
    assign wr_data = c_q.wr_data;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R1
    AST_WRITE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (busy && !done)); // R7

endmodule

// File: rtl/nvram_cksum_engine.sv
module nvram_cksum_engine #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] byte_cnt,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    output logic          busy,
    output logic          done,
    output logic [15:0]   result,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    localparam logic [CW-1:0] EVEN_MASK = ~CW'(1);

    logic          accept;
    logic [CW-1:0] cnt_even;
    logic          cnt_odd;
    logic          cnt_zero;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;
    logic [15:0]   fold_crc;
    logic [15:0]   fold_word;
    logic [15:0]   fold_out;

    assign accept   = start && !busy;
    assign cnt_even = byte_cnt & EVEN_MASK;
    assign cnt_odd  = byte_cnt[0];
    assign cnt_zero = (byte_cnt == '0);

    nvck_fold u_fold (
        .crc_in  (fold_crc),
        .word_in (fold_word),
        .crc_out (fold_out)
    );

    nvck_fetch #(.AW(AW), .CW(CW)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .base     (base_addr),
        .cnt_even (cnt_even),
        .cnt_zero (cnt_zero),
        .rd_en    (mem_rd_en),
        .rd_addr  (rd_addr)
    );

    nvck_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cnt_even  (cnt_even),
        .cnt_odd   (cnt_odd),
        .cnt_zero  (cnt_zero),
        .wb_en     (wb_en),
        .wb_addr   (wb_addr),
        .rdata     (mem_rdata),
        .fold_out  (fold_out),
        .fold_crc  (fold_crc),
        .fold_word (fold_word),
        .busy      (busy),
        .done      (done),
        .crc       (result),
        .wr_en     (mem_wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (mem_wdata)
    );

    assign mem_addr = mem_wr_en ? wr_addr : rd_addr;

    AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R7
    AST_WB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !$past(mem_wr_en)) |=> (mem_wr_en && (mem_addr == $past(mem_addr) + AW'(1)))); // R7
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (byte_cnt == '0) && !wb_en) |=> (done && (result == 16'hFFFF))); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result)); // R8

endmodule

// File: tb/tb_nvram_cksum_engine.sv
module tb_nvram_cksum_engine;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic          wb_en = 1'b0;
    logic [AW-1:0] wb_addr = '0;
    logic          busy, done, mem_rd_en, mem_wr_en;
    logic [15:0]   result;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = 8'h00;

    logic [7:0] mem [0:1023];

    int n_chk = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int rd_first = -1;
    int rd_last = -1;
    int rd_gap_err = 0;
    int wr_hi_addr = -1;
    int wr_lo_addr = -1;

    always #4 clk = ~clk;

    nvram_cksum_engine #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .byte_cnt(byte_cnt), .wb_en(wb_en), .wb_addr(wb_addr),
        .busy(busy), .done(done), .result(result),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // byte memory, one-cycle read latency, with access trace
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[9:0]];
            if (rd_cnt == 0) rd_first = int'(mem_addr);
            else if (int'(mem_addr) != rd_last + 1) rd_gap_err = rd_gap_err + 1;
            rd_last = int'(mem_addr);
            rd_cnt  = rd_cnt + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            if (wr_cnt == 0) wr_hi_addr = int'(mem_addr);
            else             wr_lo_addr = int'(mem_addr);
            wr_cnt = wr_cnt + 1;
        end
    end

    function automatic logic [15:0] mdl_step(input logic [15:0] acc, input logic [15:0] w);
        logic [15:0] x, lo, hi;
        x  = acc ^ w;
        lo = x & 16'h000F;
        hi = ((x >> 4) & 16'h000F) ^ lo;
        return (acc >> 8) ^ (lo << 3) ^ (lo << 8) ^ hi ^ (hi << 7) ^ (hi << 12);
    endfunction

    function automatic logic [15:0] mdl_sum(input int s, input int c);
        logic [15:0] acc = 16'hFFFF;
        int n = c - (c % 2);
        for (int i = 0; i < n; i++)
            acc = mdl_step(acc, {mem[(s + i) % 1024], mem[(s + i + 1) % 1024]});
        if (c % 2 == 1)
            acc = mdl_step(acc, {mem[(s + n) % 1024], 8'h00});
        return acc;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_trace();
        rd_cnt = 0; wr_cnt = 0; rd_first = -1; rd_last = -1;
        rd_gap_err = 0; wr_hi_addr = -1; wr_lo_addr = -1;
    endtask

    task automatic run_job(input int s, input int c, input bit w, input int wa,
                           output logic [15:0] res, output int cyc);
        @(negedge clk);
        clear_trace();
        base_addr = AW'(s); byte_cnt = CW'(c); wb_en = w; wb_addr = AW'(wa);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk("R1 busy after accept", int'(busy), 1);
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk("R1 job timeout", 0, 1);
        res = result;
    endtask

    task automatic t_reset();
        chk("R1 reset busy", int'(busy), 0);
        chk("R8 reset done", int'(done), 0);
        chk("R6 reset read", int'(mem_rd_en), 0);
        chk("R9 reset write", int'(mem_wr_en), 0);
    endtask

    task automatic t_zero();
        logic [15:0] r; int cyc;
        run_job(16'h0040, 0, 1'b0, 0, r, cyc);
        chk("R2 zero result", int'(r), 16'hFFFF);
        chk("R2 zero latency", cyc, 1);
        chk("R2 zero reads", rd_cnt, 0);
    endtask

    task automatic t_hand_values();
        logic [15:0] r; int cyc;
        mem[16'h0200] = 8'h00;
        run_job(16'h0200, 1, 1'b0, 0, r, cyc);
        chk("R3 R5 single zero byte", int'(r), 16'h0F87);
        chk("R6 single byte reads", rd_cnt, 1);
        mem[16'h0210] = 8'hFF; mem[16'h0211] = 8'hFF; mem[16'h0212] = 8'hFF;
        run_job(16'h0210, 2, 1'b0, 0, r, cyc);
        chk("R4 three FF bytes", int'(r), 16'h0000);
        chk("R6 count2 reads", rd_cnt, 3);
    endtask

    task automatic t_even();
        logic [15:0] r; int cyc;
        run_job(16'h0100, 16'h40, 1'b0, 0, r, cyc);
        chk("R4 even region", int'(r), int'(mdl_sum(16'h0100, 16'h40)));
        chk("R6 even read count", rd_cnt, 16'h41);
        chk("R6 even first addr", rd_first, 16'h0100);
        chk("R6 even last addr", rd_last, 16'h0140);
        chk("R6 even ascending", rd_gap_err, 0);
        chk("R9 no writes", wr_cnt, 0);
        @(negedge clk);
        chk("R8 done single cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        chk("R8 result held", int'(result), int'(r));
    endtask

    task automatic t_odd();
        logic [15:0] r; int cyc;
        run_job(16'h0180, 16'h25, 1'b0, 0, r, cyc);
        chk("R5 odd region", int'(r), int'(mdl_sum(16'h0180, 16'h25)));
        chk("R6 odd read count", rd_cnt, 16'h25);
        chk("R6 odd last addr", rd_last, 16'h0180 + 16'h24);
    endtask

    task automatic t_header();
        logic [15:0] r, r2, ex; int cyc;
        ex = mdl_sum(0, 16'hF8);
        run_job(0, 16'hF8, 1'b1, 16'h00FC, r, cyc);
        chk("R10 header checksum", int'(r), int'(ex));
        chk("R7 write count", wr_cnt, 2);
        chk("R7 hi address", wr_hi_addr, 16'h00FC);
        chk("R7 lo address", wr_lo_addr, 16'h00FD);
        chk("R7 stored hi", int'(mem[16'h00FC]), int'(r[15:8]));
        chk("R7 stored lo", int'(mem[16'h00FD]), int'(r[7:0]));
        run_job(0, 16'hF8, 1'b0, 0, r2, cyc);
        chk("R10 recompute stable", int'(r2), int'(r));
    endtask

    task automatic t_collisions();
        logic [15:0] r, ex; int cyc;
        ex = mdl_sum(16'h0300, 16'h30);
        fork
            run_job(16'h0300, 16'h30, 1'b0, 0, r, cyc);
            begin
                repeat (8) @(negedge clk);
                base_addr = 16'h0000; byte_cnt = 16'h0000; wb_en = 1'b1; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        chk("R1 mid-job start ignored", int'(r), int'(ex));
        chk("R1 mid-job read count", rd_cnt, 16'h31);
        chk("R1 mid-job no write", wr_cnt, 0);
        // start raised during the done cycle must be refused
        base_addr = 16'h0010; byte_cnt = 16'h0000; wb_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 done-cycle start busy", int'(busy), 0);
        chk("R1 done-cycle start done", int'(done), 0);
        chk("R8 result after refused start", int'(result), int'(ex));
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_hand_values();
        t_even();
        t_odd();
        t_header();
        t_collisions();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule